// File: doc/BRIEF.md
# PWM Fault Override Controller

This block sits between a PWM generator and the output pins of four complementary channel pairs, which gives eight pins. In normal running it passes the raw high-side and low-side PWM levels to the pins through one output register. It applies a high-side polarity control to the high-side pins and a separate low-side polarity control to the low-side pins. Each pin also has an enable. A disabled pin has its output enable driven low, so that general-purpose I/O logic can use that pin.

There are two active-low fault inputs, A and B. Each one is synchronized and has its own per-pair enables and its own per-pin override states. Each fault has an interrupt flag, which software clears with a one-cycle strobe. A fault takes over the enabled pairs as soon as its synchronized sample goes low. The pins return to normal PWM only on a cycle or half-cycle boundary strobe.

Each fault can run in one of two modes:
- Cycle-by-cycle mode releases the override at the first boundary after the fault input goes high again.
- Latched mode also waits until software has cleared the flag.

A configuration input sets the pin state during reset. The pins are either driven to their inactive levels or tri-stated.

Top module: `pwm_fault_guard`

## Requirements
- R1: Both fault inputs are active low. Each one passes through a two-flop synchronizer. When a fault input goes low just after a clock edge, the override is visible on `pin_out` after the 4th following rising edge and not before.
- R2: A fault overrides pair p only when bit p of that fault's pair-enable vector is set. With all four bits clear, a fault leaves every pin unchanged.
- R3: Pin index 2p is the high-side pin of pair p, and pin index 2p+1 is its low-side pin. This order applies to `pin_out`, `pin_oe`, `cfg_pin_en` and both override-state vectors. An override-state bit of 1 forces the pin active, and 0 forces it inactive.
- R4: `cfg_hi_act_low` or `cfg_lo_act_low` set to 1 makes every high-side or low-side pin active-low: the pin level is the inverse of the logical state. Setting either bit to 0 makes those pins active-high. This holds both for PWM pass-through and for override states.
- R5: If pair p has bit p of `cfg_pair_compl` set and its override state asks for both pins active, the high-side pin goes active and the low-side pin is held inactive.
- R6: If both faults are asserted and enabled for the same pair, that pair takes fault A's override states.
- R7: In cycle-by-cycle mode (`cfg_*_latch` = 0), the override holds while the synchronized fault input is low. After the input goes high, the override ends at the first edge where `pwm_boundary` is 1, and the pins show normal PWM one edge later.
- R8: In latched mode (`cfg_*_latch` = 1), a boundary ends the override only when both of these hold: the synchronized input is high, and the fault flag is clear. A flag cleared while the fault is still low leaves the override in place until the input goes high and a boundary arrives.
- R9: A fault flag sets on the edge after the first low synchronized sample, which is the 3rd edge after the pin falls. The flag clears on the edge after `sw_clr_*` is 1. If a set and a clear fall on the same edge, the set wins.
- R10: After reset, `pin_oe` equals `cfg_pin_en`. A disabled pin has its output enable low.
- R11: While `rst_n` is low, every pin is driven to its inactive level (as set by the polarity bits), and `pin_oe` is all ones if `cfg_reset_tristate` is 0 and all zeros if it is 1. Both fault flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_hi | input | 4 | Raw high-side PWM, one bit per pair |
| pwm_lo | input | 4 | Raw low-side PWM, one bit per pair |
| pwm_boundary | input | 1 | Cycle or half-cycle boundary strobe |
| flt_a_n | input | 1 | Fault A, active low, asynchronous |
| flt_b_n | input | 1 | Fault B, active low, asynchronous |
| cfg_a_pair_en | input | 4 | Fault A pair enables |
| cfg_b_pair_en | input | 4 | Fault B pair enables |
| cfg_a_state | input | 8 | Fault A per-pin override states |
| cfg_b_state | input | 8 | Fault B per-pin override states |
| cfg_a_latch | input | 1 | Fault A mode: 1 latched, 0 cycle-by-cycle |
| cfg_b_latch | input | 1 | Fault B mode: 1 latched, 0 cycle-by-cycle |
| cfg_pair_compl | input | 4 | Per-pair complementary mode |
| cfg_hi_act_low | input | 1 | High-side pins active-low |
| cfg_lo_act_low | input | 1 | Low-side pins active-low |
| cfg_pin_en | input | 8 | Per-pin output enable |
| cfg_reset_tristate | input | 1 | Pin policy during reset: 1 tri-state, 0 drive inactive |
| sw_clr_a | input | 1 | Clear strobe for fault A flag |
| sw_clr_b | input | 1 | Clear strobe for fault B flag |
| pin_out | output | 8 | Pin levels |
| pin_oe | output | 8 | Pin output enables |
| flt_a_flag | output | 1 | Fault A interrupt flag |
| flt_b_flag | output | 1 | Fault B interrupt flag |

## Verification
A flag set and a software clear can land on the same edge. The bench provokes this by holding `sw_clr_b` high across the whole fall of fault B. The flag must read 1 right after the setting edge and 0 one edge later, which shows that the set won and the standing clear then took effect.

Fault A and fault B can also claim the same pair in the same cycle. The bench asserts both with conflicting override states on a shared pair. It then checks that the shared pair shows A's states while a pair enabled only for B shows B's states.

// File: rtl/pwm_fault_guard_pkg.sv
// Package: shared constants, types and helpers for the PWM fault override controller.
// Assumes: pin index 2p is the high side and 2p+1 the low side of pair p.
package pwm_fault_guard_pkg;

    localparam int NUM_FAULTS = 2;
    localparam int FLT_A      = 0;
    localparam int FLT_B      = 1;

    typedef enum logic {
        MODE_CYCLE = 1'b0,
        MODE_LATCH = 1'b1
    } flt_mode_e;

    // Index of the high-side pin for a given pair.
    function automatic int hi_idx(input int pair);
        return 2 * pair;
    endfunction

    // Index of the low-side pin for a given pair.
    function automatic int lo_idx(input int pair);
        return 2 * pair + 1;
    endfunction

endpackage

// File: rtl/flt_input_ctl.sv
// Module: one fault input channel. Synchronizes the active-low pin, keeps the
// interrupt flag and the override hold state, and releases the hold only on a
// boundary strobe under the rules of the selected mode.
// Assumes: flt_n is asynchronous; clr and bnd are single-cycle synchronous strobes.
module flt_input_ctl
    import pwm_fault_guard_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      flt_n,
    input  logic      bnd,
    input  logic      clr,
    input  flt_mode_e mode,
    output logic      hold,
    output logic      flag
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] sync_q;
    logic          smp;
    logic          smp_d;

    assign smp = sync_q[LAST];

    // Shift the raw pin through the synchronizer chain; the idle level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            smp_d  <= 1'b1;
        end else begin
            sync_q <= {sync_q[LAST-1:0], flt_n};
            smp_d  <= smp;
        end
    end

    // Set the flag on the first low synchronized sample; a set beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (smp_d && !smp)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

    // Enter the override at once on a low sample; leave it only at a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold <= 1'b0;
        else if (!smp)
            hold <= 1'b1;
        else if (bnd && (mode == MODE_CYCLE || !flag))
            hold <= 1'b0;
    end

    assert_flag_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_d && !smp) |=> flag);

    assert_hold_needs_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !bnd) |=> hold);

    assert_latched_waits_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && flag && mode == MODE_LATCH) |=> hold);

    assert_low_forces_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp) |=> hold);

endmodule

// File: rtl/pair_override.sv
// Module: output selection for one complementary pair. Picks fault A, then
// fault B, then raw PWM. Applies the complementary high-side-wins rule and
// the per-side polarity.
// Assumes: hold inputs are registered; outputs are combinational pin levels.
module pair_override (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold_a,
    input  logic       hold_b,
    input  logic       en_a,
    input  logic       en_b,
    input  logic [1:0] st_a,
    input  logic [1:0] st_b,
    input  logic       compl,
    input  logic       pwm_h,
    input  logic       pwm_l,
    input  logic       act_low_h,
    input  logic       act_low_l,
    output logic       lvl_h,
    output logic       lvl_l
);

    logic       own_a;
    logic       own_b;
    logic       forced;
    logic [1:0] st_sel;
    logic       log_h;
    logic       log_l;

    // Decide which fault owns the pair; fault A is checked first.
    always_comb begin
        own_a  = hold_a && en_a;
        own_b  = hold_b && en_b;
        forced = own_a || own_b;
        st_sel = own_a ? st_a : st_b;
    end

    // Logical active states, with the high side winning in complementary mode.
    always_comb begin
        if (forced) begin
            log_h = st_sel[0];
            log_l = st_sel[1] && !(compl && st_sel[0]);
        end else begin
            log_h = pwm_h;
            log_l = pwm_l;
        end
    end

    // Map the logical state to pin levels through the polarity controls.
    always_comb begin
        lvl_h = log_h ^ act_low_h;
        lvl_l = log_l ^ act_low_l;
    end

    assert_compl_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (forced && compl) |-> !(log_h && log_l));

endmodule

// File: rtl/pwm_fault_guard.sv
// Module: top of the PWM fault override controller. Builds two fault
// channels and one selector per pair, then registers the pin levels and
// output enables under the reset-time pin policy.
// Assumes: synchronous active-low reset; pwm_boundary is a one-cycle strobe.
module pwm_fault_guard
    import pwm_fault_guard_pkg::*;
#(
    parameter int NPAIR = 4,
    parameter int NPIN  = 2 * NPAIR
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPAIR-1:0] pwm_hi,
    input  logic [NPAIR-1:0] pwm_lo,
    input  logic             pwm_boundary,
    input  logic             flt_a_n,
    input  logic             flt_b_n,
    input  logic [NPAIR-1:0] cfg_a_pair_en,
    input  logic [NPAIR-1:0] cfg_b_pair_en,
    input  logic [NPIN-1:0]  cfg_a_state,
    input  logic [NPIN-1:0]  cfg_b_state,
    input  logic             cfg_a_latch,
    input  logic             cfg_b_latch,
    input  logic [NPAIR-1:0] cfg_pair_compl,
    input  logic             cfg_hi_act_low,
    input  logic             cfg_lo_act_low,
    input  logic [NPIN-1:0]  cfg_pin_en,
    input  logic             cfg_reset_tristate,
    input  logic             sw_clr_a,
    input  logic             sw_clr_b,
    output logic [NPIN-1:0]  pin_out,
    output logic [NPIN-1:0]  pin_oe,
    output logic             flt_a_flag,
    output logic             flt_b_flag
);

    logic [NUM_FAULTS-1:0] flt_n_v;
    logic [NUM_FAULTS-1:0] clr_v;
    logic [NUM_FAULTS-1:0] latch_v;
    logic [NUM_FAULTS-1:0] hold_v;
    logic [NUM_FAULTS-1:0] flag_v;
    logic [NPIN-1:0]       lvl;
    logic [NPIN-1:0]       idle_lvl;

    assign flt_n_v = {flt_b_n, flt_a_n};
    assign clr_v   = {sw_clr_b, sw_clr_a};
    assign latch_v = {cfg_b_latch, cfg_a_latch};

    // One control channel per fault input.
    for (genvar f = 0; f < NUM_FAULTS; f++) begin : g_flt
        flt_input_ctl #(.SYNC_STAGES(2)) u_ctl (
            .clk   (clk),
            .rst_n (rst_n),
            .flt_n (flt_n_v[f]),
            .bnd   (pwm_boundary),
            .clr   (clr_v[f]),
            .mode  (flt_mode_e'(latch_v[f])),
            .hold  (hold_v[f]),
            .flag  (flag_v[f])
        );
    end

    // One selector per pair, plus the inactive level used during reset.
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        pair_override u_sel (
            .clk       (clk),
            .rst_n     (rst_n),
            .hold_a    (hold_v[FLT_A]),
            .hold_b    (hold_v[FLT_B]),
            .en_a      (cfg_a_pair_en[p]),
            .en_b      (cfg_b_pair_en[p]),
            .st_a      (cfg_a_state[2*p+1 -: 2]),
            .st_b      (cfg_b_state[2*p+1 -: 2]),
            .compl     (cfg_pair_compl[p]),
            .pwm_h     (pwm_hi[p]),
            .pwm_l     (pwm_lo[p]),
            .act_low_h (cfg_hi_act_low),
            .act_low_l (cfg_lo_act_low),
            .lvl_h     (lvl[hi_idx(p)]),
            .lvl_l     (lvl[lo_idx(p)])
        );
        assign idle_lvl[hi_idx(p)] = cfg_hi_act_low;
        assign idle_lvl[lo_idx(p)] = cfg_lo_act_low;
    end

    // Register pin levels and enables; reset applies the pin policy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_out <= idle_lvl;
            pin_oe  <= {NPIN{!cfg_reset_tristate}};
        end else begin
            pin_out <= lvl;
            pin_oe  <= cfg_pin_en;
        end
    end

    assign flt_a_flag = flag_v[FLT_A];
    assign flt_b_flag = flag_v[FLT_B];

    assert_oe_within_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((pin_oe & ~$past(cfg_pin_en)) == '0));

endmodule

// File: tb/pwm_fault_guard_bench.sv
module pwm_fault_guard_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 4;

    // Vector: pwm_hi, pwm_lo, hi_act_low, lo_act_low, pin_en, exp_out, exp_oe
    typedef struct packed {
        logic [3:0] hi;
        logic [3:0] lo;
        logic       ph;
        logic       pl;
        logic [7:0] en;
        logic [7:0] eo;
        logic [7:0] eoe;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{4'b0000, 4'b1111, 1'b0, 1'b0, 8'hFF, 8'hAA, 8'hFF},
        '{4'b1111, 4'b0000, 1'b1, 1'b0, 8'hFF, 8'h00, 8'hFF},
        '{4'b0101, 4'b0011, 1'b0, 1'b1, 8'h0F, 8'hB1, 8'h0F},
        '{4'b1010, 4'b0101, 1'b1, 1'b1, 8'hF0, 8'h99, 8'hF0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pwm_hi = 4'h0;
    logic [3:0] pwm_lo = 4'hF;
    logic       pwm_boundary = 1'b0;
    logic       flt_a_n = 1'b1;
    logic       flt_b_n = 1'b1;
    logic [3:0] cfg_a_pair_en = 4'h0;
    logic [3:0] cfg_b_pair_en = 4'h0;
    logic [7:0] cfg_a_state = 8'h00;
    logic [7:0] cfg_b_state = 8'h00;
    logic       cfg_a_latch = 1'b0;
    logic       cfg_b_latch = 1'b0;
    logic [3:0] cfg_pair_compl = 4'h0;
    logic       cfg_hi_act_low = 1'b0;
    logic       cfg_lo_act_low = 1'b0;
    logic [7:0] cfg_pin_en = 8'hFF;
    logic       cfg_reset_tristate = 1'b1;
    logic       sw_clr_a = 1'b0;
    logic       sw_clr_b = 1'b0;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic       flt_a_flag;
    logic       flt_b_flag;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_fault_guard u_pwm_fault_guard (
        .clk(clk), .rst_n(rst_n), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
        .pwm_boundary(pwm_boundary), .flt_a_n(flt_a_n), .flt_b_n(flt_b_n),
        .cfg_a_pair_en(cfg_a_pair_en), .cfg_b_pair_en(cfg_b_pair_en),
        .cfg_a_state(cfg_a_state), .cfg_b_state(cfg_b_state),
        .cfg_a_latch(cfg_a_latch), .cfg_b_latch(cfg_b_latch),
        .cfg_pair_compl(cfg_pair_compl), .cfg_hi_act_low(cfg_hi_act_low),
        .cfg_lo_act_low(cfg_lo_act_low), .cfg_pin_en(cfg_pin_en),
        .cfg_reset_tristate(cfg_reset_tristate), .sw_clr_a(sw_clr_a),
        .sw_clr_b(sw_clr_b), .pin_out(pin_out), .pin_oe(pin_oe),
        .flt_a_flag(flt_a_flag), .flt_b_flag(flt_b_flag)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bnd_pulse;
        pwm_boundary = 1'b1;
        tick(1);
        pwm_boundary = 1'b0;
        tick(1);
    endtask

    task automatic clr_both;
        sw_clr_a = 1'b1;
        sw_clr_b = 1'b1;
        tick(1);
        sw_clr_a = 1'b0;
        sw_clr_b = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R11: reset policy, tri-state then driven inactive
        tick(2);
        chk("R11 tristate out", pin_out, 8'h00);
        chk("R11 tristate oe", pin_oe, 8'h00);
        chk("R11 flags", {6'b0, flt_b_flag, flt_a_flag}, 8'h00);
        cfg_reset_tristate = 1'b0;
        cfg_hi_act_low = 1'b1;
        tick(1);
        chk("R11 driven out", pin_out, 8'h55);
        chk("R11 driven oe", pin_oe, 8'hFF);
        cfg_hi_act_low = 1'b0;
        rst_n = 1'b1;
        tick(2);

        // R4 R10: table walk through pass-through, polarity and pin enables
        for (int i = 0; i < NVEC; i++) begin
            pwm_hi = VECS[i].hi;
            pwm_lo = VECS[i].lo;
            cfg_hi_act_low = VECS[i].ph;
            cfg_lo_act_low = VECS[i].pl;
            cfg_pin_en = VECS[i].en;
            tick(1);
            chk("R4 table out", pin_out, VECS[i].eo);
            chk("R10 table oe", pin_oe, VECS[i].eoe);
        end
        pwm_hi = 4'h0; pwm_lo = 4'hF;
        cfg_hi_act_low = 1'b0; cfg_lo_act_low = 1'b0; cfg_pin_en = 8'hFF;
        tick(1);
        chk("R4 baseline", pin_out, 8'hAA);

        // R1 R3 R7 R9: cycle-by-cycle fault A on pair 0
        cfg_a_pair_en = 4'b0001; cfg_a_state = 8'h01;
        flt_a_n = 1'b0;
        tick(3);
        chk("R1 not yet", pin_out, 8'hAA);
        chk("R9 flag set", {7'b0, flt_a_flag}, 8'h01);
        tick(1);
        chk("R1 R3 override", pin_out, 8'hA9);
        flt_a_n = 1'b1;
        tick(6);
        chk("R7 held until boundary", pin_out, 8'hA9);
        bnd_pulse();
        chk("R7 released", pin_out, 8'hAA);
        sw_clr_a = 1'b1; tick(1); sw_clr_a = 1'b0;
        chk("R9 flag cleared", {7'b0, flt_a_flag}, 8'h00);

        // R2: no pair enabled means no effect
        cfg_a_pair_en = 4'b0000;
        flt_a_n = 1'b0;
        tick(6);
        chk("R2 no effect", pin_out, 8'hAA);
        flt_a_n = 1'b1;
        tick(3);
        bnd_pulse();
        clr_both();

        // R5: complementary pair 0 high wins, plain pair 1 both active
        cfg_pair_compl = 4'b0001; cfg_a_pair_en = 4'b0011; cfg_a_state = 8'h0F;
        flt_a_n = 1'b0;
        tick(4);
        chk("R5 high wins", pin_out, 8'hAD);
        flt_a_n = 1'b1;
        tick(3);
        bnd_pulse();
        chk("R5 released", pin_out, 8'hAA);
        clr_both();

        // R6: fault A over fault B on shared pair 0, B alone on pair 2
        cfg_pair_compl = 4'b0000;
        cfg_a_pair_en = 4'b0001; cfg_a_state = 8'h00;
        cfg_b_pair_en = 4'b0101; cfg_b_state = 8'h13;
        flt_a_n = 1'b0; flt_b_n = 1'b0;
        tick(4);
        chk("R6 A priority", pin_out, 8'h98);
        flt_a_n = 1'b1; flt_b_n = 1'b1;
        tick(3);
        bnd_pulse();
        chk("R6 released", pin_out, 8'hAA);
        clr_both();

        // R4: polarity applied to override states
        cfg_b_pair_en = 4'b0000;
        cfg_hi_act_low = 1'b1; cfg_lo_act_low = 1'b1;
        cfg_a_pair_en = 4'b0001; cfg_a_state = 8'h01;
        flt_a_n = 1'b0;
        tick(4);
        chk("R4 override polarity", pin_out, 8'h56);
        flt_a_n = 1'b1;
        tick(3);
        bnd_pulse();
        chk("R4 pass polarity", pin_out, 8'h55);
        clr_both();
        cfg_hi_act_low = 1'b0; cfg_lo_act_low = 1'b0;

        // R8: latched mode, flag still set at boundary
        cfg_a_latch = 1'b1;
        flt_a_n = 1'b0;
        tick(4);
        chk("R8 latched override", pin_out, 8'hA9);
        flt_a_n = 1'b1;
        tick(3);
        bnd_pulse();
        chk("R8 flag blocks release", pin_out, 8'hA9);
        sw_clr_a = 1'b1; tick(1); sw_clr_a = 1'b0;
        bnd_pulse();
        chk("R8 released after clear", pin_out, 8'hAA);
        // R8: flag cleared while fault still present
        flt_a_n = 1'b0;
        tick(4);
        sw_clr_a = 1'b1; tick(1); sw_clr_a = 1'b0;
        bnd_pulse();
        chk("R8 pin low blocks release", pin_out, 8'hA9);
        flt_a_n = 1'b1;
        tick(3);
        chk("R8 waits boundary", pin_out, 8'hA9);
        bnd_pulse();
        chk("R8 released after pin high", pin_out, 8'hAA);
        cfg_a_latch = 1'b0;

        // R9: set and clear on the same edge, set wins
        sw_clr_b = 1'b1;
        flt_b_n = 1'b0;
        tick(3);
        chk("R9 set beats clear", {7'b0, flt_b_flag}, 8'h01);
        tick(1);
        chk("R9 clear after set", {7'b0, flt_b_flag}, 8'h00);
        sw_clr_b = 1'b0;
        flt_b_n = 1'b1;
        tick(3);
        bnd_pulse();

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule